// File: doc/BRIEF.md
# Multiplexed Bus Interface Decoder

This block sits on a 16-bit controller bus where the same lines carry the address first and the data afterwards. A one-cycle address strobe captures the address and an instruction-fetch qualifier. The captured pair then selects exactly one target for the rest of the bus cycle: an internal program store, an internal data store, a byte-wide general-purpose port, or one of several external I/O selects. The fetch qualifier separates the code space from the data space, so no page register is needed.

While a read or write strobe is active, the block asserts the enable of the chosen target. In the same cycle it reports the bus width (16 or 8 bits) and READY. READY is immediate for the internal targets. For an external select it waits a programmable number of strobe cycles. On reads from an internal target the block drives the output half of the shared bus and raises an output enable. A low output enable stands for a high-impedance bus. The program store is a computed read-only table. The data store is a synchronous word array.

Top module: `mbus_decoder`

## Requirements
- R1: After reset all target enables, `ready`, `bus16` and `ad_oe` are 0, `ad_out` is 0 and `port_out` is 0.
- R2: The address and qualifier are captured at the clock edge where `ale` is 1. Later changes on `ad_in` do not alter the selection until the next `ale`.
- R3: With qualifier `inst`=1 captured, the target is the program store, whatever the address.
- R4: With `inst`=0 the map is as follows. Address bits [15:8] = 0xF0 select the port. Bits [15:12]=0xF with bits [11:8]=k, where 1<=k<=NCS, select `io_cs[k-1]`. Every other address selects the data store at index address[DATA_AW-1:0]. Aliases wrap.
- R5: At most one of `prog_en`, `data_en`, `port_en`, `io_cs` is 1 at any time. Exactly one is 1 while `rd` or `wr` is active, and none is 1 otherwise.
- R6: A program-store read at index i = address[14:0] returns ((i*0x9E37) mod 2^16) XOR 0xC3A5. Writes to the program store have no effect.
- R7: A data-store write stores the full 16-bit `ad_in` word in one strobe cycle. A later read of that index returns it.
- R8: A port read returns {8'h00, `port_in`}. A port write loads `ad_in[7:0]` into `port_out` at the end of the first strobe cycle, and the value holds afterwards.
- R9: While a strobe is active, `bus16` is 1 for the program and data stores and 0 for the port and the external selects.
- R10: `ready` is 1 in every strobe cycle for internal targets (program store, data store, port). For an external select it is 0 for the first WAIT_CYC strobe cycles and 1 afterwards.
- R11: `ad_oe` is 1 only during `rd` to an internal target. Otherwise `ad_oe` is 0 and `ad_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ale | input | 1 | Address capture strobe |
| inst | input | 1 | Instruction-fetch qualifier |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ad_in | input | 16 | Shared bus, input side |
| ad_out | output | 16 | Shared bus, output side |
| ad_oe | output | 1 | Bus drive enable |
| prog_en | output | 1 | Program store selected |
| data_en | output | 1 | Data store selected |
| port_en | output | 1 | Port selected |
| io_cs | output | NCS | External I/O selects |
| ready | output | 1 | Cycle may complete |
| bus16 | output | 1 | 1 = 16-bit target |
| port_in | input | 8 | Port input pins |
| port_out | output | 8 | Port output register |

## Verification
The tests use code fetches at low and top indices, including a fetch whose address falls in the I/O window. This shows that the qualifier outranks the address map. Data writes followed by reads, including an aliased address, show that the full word is stored and that the index wraps. External selects are tried at the first and last select number, and one number above the range. The multi-cycle strobes show the wait count and confirm that the bus stays undriven. During every read strobe the bus input carries unrelated data, so a decoder that followed the live bus instead of the captured address would be exposed.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  typedef enum logic [1:0] {
    TGT_PROG = 2'd0,
    TGT_DATA = 2'd1,
    TGT_PORT = 2'd2,
    TGT_XCS  = 2'd3
  } tgt_e;

  // Target chosen from the captured qualifier and address high byte.
  function automatic tgt_e pick_target(input logic fetch, input logic [7:0] hi, input int ncs);
    if (fetch)
      return TGT_PROG;
    if (hi[7:4] == 4'hF && hi[3:0] == 4'h0)
      return TGT_PORT;
    if (hi[7:4] == 4'hF && int'(hi[3:0]) <= ncs)
      return TGT_XCS;
    return TGT_DATA;
  endfunction

  // Contents of the read-only program store.
  function automatic logic [15:0] prog_word(input logic [14:0] idx);
    logic [31:0] prod;
    prod = {17'd0, idx} * 32'h0000_9E37;
    return prod[15:0] ^ 16'hC3A5;
  endfunction

endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          inst_in,
  input  logic [AW-1:0] ad_in,
  output logic [AW-1:0] laddr,
  output logic          linst
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      laddr <= '0;
      linst <= 1'b0;
    end else if (ale) begin
      laddr <= ad_in;
      linst <= inst_in;
    end
  end

  // R2: captured value moves only on an address strobe
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> ($stable(laddr) && $stable(linst)));

endmodule

// File: rtl/mbd_decode.sv
module mbd_decode
  import mbd_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int WAIT_CYC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           rd,
  input  logic           wr,
  input  logic           linst,
  input  logic [7:0]     lhi,
  output logic           prog_en,
  output logic           data_en,
  output logic           port_en,
  output logic [NCS-1:0] io_cs,
  output logic           ready,
  output logic           bus16
);

  localparam int CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

  tgt_e          tgt;
  logic          strobe;
  logic          cs_done;
  logic [CW-1:0] wcnt;

  assign tgt    = pick_target(linst, lhi, NCS);
  assign strobe = rd | wr;

  assign prog_en = strobe && (tgt == TGT_PROG);
  assign data_en = strobe && (tgt == TGT_DATA);
  assign port_en = strobe && (tgt == TGT_PORT);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign io_cs[g] = strobe && (tgt == TGT_XCS) && (int'(lhi[3:0]) == g + 1);
  end

  assign cs_done = (32'(wcnt) >= WAIT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wcnt <= '0;
    else if (ale)
      wcnt <= '0;
    else if (strobe && tgt == TGT_XCS && !cs_done)
      wcnt <= wcnt + 1'b1;
  end

  assign ready = strobe && ((tgt != TGT_XCS) || cs_done);
  assign bus16 = strobe && (tgt == TGT_PROG || tgt == TGT_DATA);

  // R5: never more than one target
  a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_en, data_en, port_en, io_cs}));

  // R10: first strobe cycle of an external select waits
  a_r10_cs_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ((WAIT_CYC > 0) && $rose(|io_cs)) |-> !ready);

  // R10: internal targets answer at once
  a_r10_internal_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en || data_en || port_en) |-> ready);

  // R9: width follows the selected target
  a_r9_width: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_en || data_en) |-> bus16) and ((port_en || (|io_cs)) |-> !bus16));

endmodule

// File: rtl/mbd_mem.sv
module mbd_mem
  import mbd_pkg::*;
#(
  parameter int PROG_AW = 15,
  parameter int DATA_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ale,
  input  logic [PROG_AW-1:0] prog_idx,
  input  logic [DATA_AW-1:0] data_ridx,
  input  logic [DATA_AW-1:0] data_widx,
  input  logic               data_we,
  input  logic [15:0]        wdata,
  output logic [15:0]        prog_q,
  output logic [15:0]        data_q
);

  localparam int DEPTH = 1 << DATA_AW;

  logic [15:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (data_we)
      ram[data_widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      data_q <= '0;
    end else if (ale) begin
      prog_q <= prog_word(15'(prog_idx));
      data_q <= ram[data_ridx];
    end
  end

endmodule

// File: rtl/mbus_decoder.sv
module mbus_decoder
  import mbd_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int WAIT_CYC = 2,
  parameter int PROG_AW  = 15,
  parameter int DATA_AW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           inst,
  input  logic           rd,
  input  logic           wr,
  input  logic [15:0]    ad_in,
  output logic [15:0]    ad_out,
  output logic           ad_oe,
  output logic           prog_en,
  output logic           data_en,
  output logic           port_en,
  output logic [NCS-1:0] io_cs,
  output logic           ready,
  output logic           bus16,
  input  logic [7:0]     port_in,
  output logic [7:0]     port_out
);

  logic [15:0] laddr;
  logic        linst;
  logic [15:0] prog_q;
  logic [15:0] data_q;
  logic        internal_rd;

  mbd_addr_latch #(.AW(16)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .inst_in(inst),
    .ad_in  (ad_in),
    .laddr  (laddr),
    .linst  (linst)
  );

  mbd_decode #(.NCS(NCS), .WAIT_CYC(WAIT_CYC)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .rd     (rd),
    .wr     (wr),
    .linst  (linst),
    .lhi    (laddr[15:8]),
    .prog_en(prog_en),
    .data_en(data_en),
    .port_en(port_en),
    .io_cs  (io_cs),
    .ready  (ready),
    .bus16  (bus16)
  );

  mbd_mem #(.PROG_AW(PROG_AW), .DATA_AW(DATA_AW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .prog_idx (ad_in[PROG_AW-1:0]),
    .data_ridx(ad_in[DATA_AW-1:0]),
    .data_widx(laddr[DATA_AW-1:0]),
    .data_we  (wr && data_en),
    .wdata    (ad_in),
    .prog_q   (prog_q),
    .data_q   (data_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      port_out <= '0;
    else if (wr && port_en)
      port_out <= ad_in[7:0];
  end

  assign internal_rd = rd && (prog_en || data_en || port_en);
  assign ad_oe       = internal_rd;

  always_comb begin
    ad_out = '0;
    if (internal_rd) begin
      if (prog_en)      ad_out = prog_q;
      else if (data_en) ad_out = data_q;
      else              ad_out = {8'h00, port_in};
    end
  end

  // R11: bus is driven only under a read strobe
  a_r11_oe_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> rd);

  // R11: undriven bus carries zero
  a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> (ad_out == 16'h0000));

  // R8: port register only moves on a port write
  a_r8_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && port_en) |=> $stable(port_out));

endmodule

// File: tb/tb_mbus_decoder.sv
`timescale 1ns/1ps
module tb_mbus_decoder;

  localparam int NCS  = 4;
  localparam int WAIT = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ale = 1'b0, inst = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0]    ad_in = '0;
  logic [7:0]     port_in = '0;
  logic [15:0]    ad_out;
  logic           ad_oe, prog_en, data_en, port_en, ready, bus16;
  logic [NCS-1:0] io_cs;
  logic [7:0]     port_out;

  always #2 clk = ~clk;

  mbus_decoder #(.NCS(NCS), .WAIT_CYC(WAIT), .PROG_AW(15), .DATA_AW(10)) dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .inst(inst), .rd(rd), .wr(wr),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .prog_en(prog_en),
    .data_en(data_en), .port_en(port_en), .io_cs(io_cs), .ready(ready),
    .bus16(bus16), .port_in(port_in), .port_out(port_out)
  );

  typedef struct {
    string       tag;
    logic [6:0]  en;
    logic        rdy;
    logic        w16;
    logic        oe;
    logic [15:0] dout;
    logic [7:0]  pout;
  } exp_t;

  exp_t        sbq[$];
  logic [15:0] shadow [int];
  logic [7:0]  pmodel = 8'h00;
  int          nvec = 0;
  int          nfail = 0;
  bit          done = 0;

  function automatic logic [15:0] expect_prog(input logic [15:0] a);
    int v;
    v = ((a & 16'h7FFF) * 40503) % 65536;
    return 16'(v) ^ 16'hC3A5;
  endfunction

  // 0 prog, 1 data, 2 port, 3 external select
  function automatic int kind_of(input logic i, input logic [15:0] a);
    if (i) return 0;
    if (a[15:8] == 8'hF0) return 2;
    if (a[15:12] == 4'hF && a[11:8] >= 1 && a[11:8] <= NCS) return 3;
    return 1;
  endfunction

  task automatic push_idle(input string tag);
    exp_t e;
    e.tag = tag; e.en = '0; e.rdy = 0; e.w16 = 0; e.oe = 0; e.dout = '0; e.pout = pmodel;
    sbq.push_back(e);
  endtask

  task automatic bus_op(input string tag, input logic i, input logic [15:0] a,
                        input bit is_rd, input bit is_wr, input logic [15:0] wd, input int n);
    int          kd;
    logic [15:0] rv;
    exp_t        e;
    kd = kind_of(i, a);
    case (kd)
      0: rv = expect_prog(a);
      1: rv = shadow.exists(int'(a & 16'h03FF)) ? shadow[int'(a & 16'h03FF)] : 16'h0000;
      2: rv = {8'h00, port_in};
      default: rv = 16'h0000;
    endcase
    @(posedge clk); #1;
    ale = 1; inst = i; rd = 0; wr = 0; ad_in = a;
    push_idle(tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      ale = 0; inst = ~i; rd = is_rd; wr = is_wr; ad_in = is_wr ? wd : 16'hDEAD;
      e.tag  = tag;
      e.en   = '0;
      case (kd)
        0: e.en[6] = 1'b1;
        1: e.en[5] = 1'b1;
        2: e.en[4] = 1'b1;
        default: e.en[int'(a[11:8]) - 1] = 1'b1;
      endcase
      e.rdy  = (kd != 3) || (k >= WAIT);
      e.w16  = (kd <= 1);
      e.oe   = is_rd && (kd != 3);
      e.dout = e.oe ? rv : 16'h0000;
      e.pout = pmodel;
      sbq.push_back(e);
      if (is_wr && kd == 1) shadow[int'(a & 16'h03FF)] = wd;
      if (is_wr && kd == 2) pmodel = wd[7:0];
    end
    @(posedge clk); #1;
    rd = 0; wr = 0; ad_in = 16'h0000;
    push_idle(tag);
  endtask

  // Monitor: pop one expectation per cycle, compare mid-cycle
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      nvec++;
      if ({prog_en, data_en, port_en, io_cs} !== e.en || ready !== e.rdy || bus16 !== e.w16 ||
          ad_oe !== e.oe || ad_out !== e.dout || port_out !== e.pout) begin
        nfail++;
        $display("FAIL %s: en=%b rdy=%b w16=%b oe=%b out=%h pout=%h expected en=%b rdy=%b w16=%b oe=%b out=%h pout=%h",
                 e.tag, {prog_en, data_en, port_en, io_cs}, ready, bus16, ad_oe, ad_out, port_out,
                 e.en, e.rdy, e.w16, e.oe, e.dout, e.pout);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    push_idle("R1 reset state");
    // R3 R6: code fetches, low and top index
    bus_op("R3 R6 fetch low",      1'b1, 16'h0123, 1, 0, 16'h0, 1);
    bus_op("R6 fetch top index",   1'b1, 16'h7FFF, 1, 0, 16'h0, 1);
    // R3: qualifier outranks the I/O window
    bus_op("R3 fetch in io window", 1'b1, 16'hF100, 1, 0, 16'h0, 2);
    // R7 R4: data write/read, aliasing
    bus_op("R7 data write",        1'b0, 16'h0010, 0, 1, 16'hBEEF, 1);
    bus_op("R7 data read",         1'b0, 16'h0010, 1, 0, 16'h0, 1);
    bus_op("R4 data write top",    1'b0, 16'h03FF, 0, 1, 16'h1234, 1);
    bus_op("R4 data alias read",   1'b0, 16'h07FF, 1, 0, 16'h0, 2);
    // R8: port
    port_in = 8'h5A;
    bus_op("R8 port read",         1'b0, 16'hF000, 1, 0, 16'h0, 1);
    bus_op("R8 port write",        1'b0, 16'hF000, 0, 1, 16'h12C3, 2);
    bus_op("R8 port hold",         1'b0, 16'h0010, 1, 0, 16'h0, 1);
    // R10 R11 R9: external selects
    bus_op("R10 R11 cs0 read",     1'b0, 16'hF100, 1, 0, 16'h0, 4);
    bus_op("R10 R9 cs3 write",     1'b0, 16'hF4AA, 0, 1, 16'h5555, 3);
    // R4: select number above range falls to data store
    bus_op("R4 beyond cs range",   1'b0, 16'hF500, 0, 1, 16'hA5A5, 1);
    bus_op("R4 beyond cs readback", 1'b0, 16'h0100, 1, 0, 16'h0, 1);
    // R6 R11: write to program store ignored, bus not driven
    bus_op("R6 R11 prog write",    1'b1, 16'h0123, 0, 1, 16'hFFFF, 1);
    bus_op("R6 prog after write",  1'b1, 16'h0123, 1, 0, 16'h0, 1);
    // R2 R5: back-to-back read with stray bus traffic
    bus_op("R2 R5 latch hold",     1'b0, 16'h0010, 1, 0, 16'h0, 3);
    wait (sbq.size() == 0);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule